// File: doc/BRIEF.md
# Timer Unit General Block: Prescaler and Free-Running Counter

This block is the shared part of a timer unit. It owns a configuration word with two independent enables: one for a tick prescaler and one for a wide free-running counter. The prescaler produces a one-cycle tick strobe that the timer channels use as their time base. Its division ratio is set by a reload register.

The free-running counter is twice the bus width. Software reads it as two bus words, low word first. Reading the low word captures the upper half into a shadow register. The following high-word read therefore returns a value consistent with the low word, even if the counter carried in between.

Access goes through a simple word-addressed register port. A read request returns data one cycle later, flagged by a valid strobe.

Top module: `tmr_gen_block`

## Requirements
- R1: After reset, the configuration word, the reload register, the counter, the shadow register and `tick_o` are all zero, and `rvalid_o` is low.
- R2: While configuration bit 0 is set, the counter increases by one on every clock cycle. While that bit is clear, the counter holds its value.
- R3: The counter wraps from all ones to zero and keeps counting.
- R4: Configuration bit 2 enables the prescaler, and `tick_o` stays low whenever bit 2 is clear. Clearing bit 2 resets the internal divider, so re-enabling it starts a full period.
- R5: With reload value r and the prescaler enabled by a write at clock edge A, `tick_o` is high for exactly one cycle after edges A+k·(r+1), for k ≥ 1. It is low in every other cycle, so the tick rate is the clock rate divided by (r+1).
- R6: A read of word 2 returns the low half of the counter at the request edge and copies the high half into the shadow register. A read of word 3 returns the shadow register.
- R7: Register map by word index: 0 holds configuration bits 0 and 2, with all other bits reading as zero. 1 holds the reload value, zero-extended. Writes to words 2 and 3 have no effect on the counter or the shadow register.
- R8: A read request at a clock edge raises `rvalid_o` with its data for the following cycle only. Writes and idle cycles leave `rvalid_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 2 | Word index |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data |
| rvalid_o | output | 1 | Read data valid |
| tick_o | output | 1 | Prescaled tick strobe |

## Verification
The bench builds the block with an 8-bit bus, a 16-bit counter and a 4-bit reload field. The small reload width lets every reload value from 0 to 15 be swept, each over several full periods plus a partial one. Each run ends in a disable and a fresh restart. The 16-bit counter makes the full wrap reachable in about 65,000 cycles. The 8-bit word split puts a low-to-high carry within a few hundred cycles, which exercises the shadow-register read across a carry.

// File: rtl/tmr_gen_pkg.sv
package tmr_gen_pkg;
  typedef enum logic [1:0] {
    REG_CFG    = 2'd0,
    REG_RELOAD = 2'd1,
    REG_CNT_LO = 2'd2,
    REG_CNT_HI = 2'd3
  } reg_idx_e;

  localparam int unsigned CFG_CNT_EN_BIT = 0;
  localparam int unsigned CFG_PRE_EN_BIT = 2;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PRE_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PRE_W-1:0] reload_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] div_q;
  logic             hit;

  // >= guards against a reload lowered below the running divider
  assign hit = (div_q >= reload_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      tick_o <= 1'b0;
    end else if (!en_i) begin
      div_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      div_q  <= hit ? '0 : div_q + 1'b1;
      tick_o <= hit;
    end
  end

  p_tick_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !tick_o);
  p_tick_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (div_q == '0));
endmodule

// File: rtl/tmr_free_counter.sv
module tmr_free_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_o <= '0;
    else if (en_i) cnt_o <= cnt_o + 1'b1;
  end

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (cnt_o == $past(cnt_o) + 1'b1));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_o));
  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (&cnt_o)) |=> (cnt_o == '0));
endmodule

// File: rtl/tmr_gen_regs.sv
module tmr_gen_regs
  import tmr_gen_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PRE_W  = 32,
  parameter int unsigned CNT_W  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              cnt_en_o,
  output logic              pre_en_o,
  output logic [PRE_W-1:0]  reload_o
);
  localparam int unsigned HALF_W = CNT_W / 2;

  logic              wr, rd;
  logic [HALF_W-1:0] shadow_q;
  logic [DATA_W-1:0] rd_mux;

  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_en_o <= 1'b0;
      pre_en_o <= 1'b0;
      reload_o <= '0;
    end else if (wr) begin
      if (reg_idx_e'(addr_i) == REG_CFG) begin
        cnt_en_o <= wdata_i[CFG_CNT_EN_BIT];
        pre_en_o <= wdata_i[CFG_PRE_EN_BIT];
      end
      if (reg_idx_e'(addr_i) == REG_RELOAD) reload_o <= wdata_i[PRE_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (reg_idx_e'(addr_i))
      REG_CFG: begin
        rd_mux[CFG_CNT_EN_BIT] = cnt_en_o;
        rd_mux[CFG_PRE_EN_BIT] = pre_en_o;
      end
      REG_RELOAD: rd_mux[PRE_W-1:0] = reload_o;
      REG_CNT_LO: rd_mux = cnt_i[HALF_W-1:0];
      REG_CNT_HI: rd_mux = shadow_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd;
      if (rd) rdata_o <= rd_mux;
      if (rd && reg_idx_e'(addr_i) == REG_CNT_LO) shadow_q <= cnt_i[CNT_W-1:HALF_W];
    end
  end

  p_rvalid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> rvalid_o);
  p_rvalid_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> !rvalid_o);
  p_shadow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == 2'd2) |=> (shadow_q == $past(cnt_i[CNT_W-1:HALF_W])));
endmodule

// File: rtl/tmr_gen_block.sv
module tmr_gen_block #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 2 * DATA_W,
  parameter int unsigned PRE_W  = DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              tick_o
);
  logic             cnt_en, pre_en;
  logic [PRE_W-1:0] reload;
  logic [CNT_W-1:0] cnt;

  initial begin
    assert (CNT_W == 2 * DATA_W) else $error("CNT_W must be twice DATA_W");
    assert (PRE_W <= DATA_W && DATA_W > 2) else $error("bad PRE_W/DATA_W");
  end

  tmr_gen_regs #(.DATA_W(DATA_W), .PRE_W(PRE_W), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o, .rvalid_o,
    .cnt_i(cnt), .cnt_en_o(cnt_en), .pre_en_o(pre_en), .reload_o(reload)
  );

  tmr_free_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .en_i(cnt_en), .cnt_o(cnt)
  );

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i, .rst_ni, .en_i(pre_en), .reload_i(reload), .tick_o
  );
endmodule

// File: tb/tmr_gen_block_tb.sv
module tmr_gen_block_tb;
  localparam int DW = 8;
  localparam int CW = 16;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0, we_i = 1'b0;
  logic [1:0]    addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          rvalid_o, tick_o;

  int errors = 0, checks = 0;
  int exp_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tmr_gen_block #(.DATA_W(DW), .CNT_W(CW), .PRE_W(PW)) u_dut (
    .clk_i(clk), .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o, .rvalid_o, .tick_o
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [DW-1:0] d);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(posedge clk); @(negedge clk);
    req_i = 0; we_i = 0;
    chk("R8 no rvalid on write", rvalid_o, 0);
  endtask

  task automatic bus_rd(input logic [1:0] a, output int d);
    req_i = 1; we_i = 0; addr_i = a;
    @(posedge clk); @(negedge clk);
    req_i = 0;
    d = rdata_o;
    chk("R8 rvalid after read", rvalid_o, 1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk_count(input string tag);
    int lo, hi;
    bus_rd(2'd2, lo);
    bus_rd(2'd3, hi);
    chk(tag, (hi << DW) | lo, exp_cnt & 16'hFFFF);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v, lo, hi, m;
    idle(2);
    rst_ni = 1;
    idle(1);
    // R1 reset state
    chk("R1 tick", tick_o, 0);
    chk("R1 rvalid", rvalid_o, 0);
    bus_rd(2'd0, v); chk("R1 cfg", v, 0);
    bus_rd(2'd1, v); chk("R1 reload", v, 0);
    chk_count("R1 count");
    idle(1);
    chk("R8 rvalid one cycle", rvalid_o, 0);

    // R7 config mask: bits 0 and 2 only (counter runs 2 cycles)
    bus_wr(2'd0, 8'hFF);
    bus_rd(2'd0, v); chk("R7 cfg mask", v, 5);
    bus_wr(2'd0, 8'h00);
    exp_cnt += 2;
    chk_count("R2 count after 2 enabled cycles");
    bus_wr(2'd1, 8'hAB);
    bus_rd(2'd1, v); chk("R7 reload zero-extended", v, 8'h0B);

    // R2 counting and holding, several spans
    foreach (m_arr[i]) begin
      bus_wr(2'd0, 8'h01);
      idle(m_arr[i]);
      bus_wr(2'd0, 8'h00);
      exp_cnt += m_arr[i] + 1;
      idle(10);
      chk_count("R2 count span");
    end

    // R7 writes to count words ignored
    bus_wr(2'd2, 8'h55);
    bus_wr(2'd3, 8'h66);
    chk_count("R7 count write ignored");

    // R4 no tick with only counter enabled
    bus_wr(2'd1, 8'h00);
    bus_wr(2'd0, 8'h01);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk("R4 no tick when prescaler off", tick_o, 0);
    end
    bus_wr(2'd0, 8'h00);
    exp_cnt += 21;
    chk_count("R2 count after run");

    // R6 shadow across a low-word carry
    m = (254 - (exp_cnt & 255)) & 255;
    if (m < 1) m += 256;
    bus_wr(2'd0, 8'h01);
    idle(m);
    bus_rd(2'd2, lo);
    chk("R6 low word", lo, (exp_cnt + m) & 255);
    idle(5);
    bus_rd(2'd3, hi);
    chk("R6 shadow high word", hi, ((exp_cnt + m) >> 8) & 255);
    bus_wr(2'd0, 8'h00);
    exp_cnt += m + 5 + 3;
    chk_count("R6 count after carry");

    // R3 wrap: run one full period plus 4
    bus_wr(2'd0, 8'h01);
    idle(65539);
    bus_wr(2'd0, 8'h00);
    exp_cnt += 65540;
    chk_count("R3 wrap");

    // R5/R4 sweep every reload value, twice each
    for (int r = 0; r < 16; r++) begin
      bus_wr(2'd1, r[7:0]);
      for (int pass = 0; pass < 2; pass++) begin
        bus_wr(2'd0, 8'h04);
        for (int k = 1; k <= 3 * (r + 1) + 1; k++) begin
          @(negedge clk);
          chk($sformatf("R5 tick r=%0d k=%0d", r, k), tick_o, (k % (r + 1)) == 0);
        end
        bus_wr(2'd0, 8'h00);
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          chk("R4 tick off after disable", tick_o, 0);
        end
      end
    end
    chk_count("R2 count held while prescaler ran");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  int m_arr[3] = '{1, 7, 40};
endmodule